// File: doc/BRIEF.md
# Indirect I/O Access Window

This block is a small slave in I/O space. It reaches a large internal address space through a window of only 32 bytes. The window holds two 32-bit registers. The first is an address pointer. The host loads it with a target location. The second is a data port. Each read or write of the data port is carried out at the location that the pointer currently holds.

The pointer value selects where a data-port access goes. Low pointer values go to a register/memory back-end port. The top half of the pointer range goes to a flash back-end port. A gap between these two regions is left undefined. Each back-end port uses a simple level request / acknowledge handshake. The host side sees a one-cycle access strobe, with a decoded word offset and byte enables. The block answers each accepted strobe with a one-cycle acknowledge.

The block answers only while the I/O base address is valid and I/O decoding is enabled.

Top module: `iow_window`

## Requirements
- R1: A write to word offset 0 (the pointer) changes the pointer only when all four byte enables are set (be = 4'b1111). Any narrower write leaves the pointer unchanged.
- R2: The pointer holds bits 19:0 only. Bits 31:20 cannot be written, and a pointer read returns them as zero. A pointer read returns all 32 bits whatever byte enables it carries.
- R3: The pointer is 0 after `rst_n` is asserted low. It also returns to 0 in the cycle after `bus_rst` is sampled high. Otherwise it keeps its value until the next full write.
- R4: A data-port access (word offset 1) with a pointer in 0x00000..0x1FFFF raises `reg_req`. That request carries `reg_addr` equal to the pointer, together with the access's write flag, byte enables and write data. A read returns `reg_rdata`.
- R5: A data-port access with a pointer in 0x80000..0xFFFFF raises `flash_req`, with `flash_addr` equal to the pointer minus 0x80000. A read returns `flash_rdata`.
- R6: A data-port access with a pointer in 0x20000..0x7FFFF raises no back-end request. A read returns 0 and a write is dropped. The access is still acknowledged one cycle after the strobe.
- R7: Word offsets 2..7 (bytes 0x08..0x1F) read as 0. Writes to them change no state: a pointer read afterwards returns the same value.
- R8: A strobe sampled while `bar_valid` or `io_dec_en` is low gets no acknowledge and has no effect, including on the pointer.
- R9: A back-end request stays high, with a stable address, until its acknowledge is sampled. At most one request is high at a time. `hst_ack` pulses one cycle after the back-end acknowledge, and one cycle after the strobe for accesses handled locally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_rst | input | 1 | Synchronous bus reset, clears the pointer |
| bar_valid | input | 1 | I/O base address holds a non-zero value |
| io_dec_en | input | 1 | I/O decoding enabled |
| hst_strobe | input | 1 | One-cycle access strobe |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_woff | input | 3 | Word offset in the window (byte offset / 4) |
| hst_be | input | 4 | Byte enables |
| hst_wdata | input | 32 | Write data |
| hst_ack | output | 1 | One-cycle access acknowledge |
| hst_rdata | output | 32 | Read data, valid with hst_ack |
| reg_req | output | 1 | Register-space request |
| reg_wr | output | 1 | Register-space write flag |
| reg_addr | output | 17 | Register-space address |
| reg_be | output | 4 | Register-space byte enables |
| reg_wdata | output | 32 | Register-space write data |
| reg_ack | input | 1 | Register-space acknowledge |
| reg_rdata | input | 32 | Register-space read data |
| flash_req | output | 1 | Flash request |
| flash_wr | output | 1 | Flash write flag |
| flash_addr | output | 19 | Flash address (pointer minus 0x80000) |
| flash_be | output | 4 | Flash byte enables |
| flash_wdata | output | 32 | Flash write data |
| flash_ack | input | 1 | Flash acknowledge |
| flash_rdata | input | 32 | Flash read data |

## Verification
Directed cases place the pointer at every region edge: 0x1FFFF, 0x20000, 0x7FFFF, 0x80000 and 0xFFFFF. These cases separate a decoder that is off by one at a boundary from a correct one, and they show whether the flash offset subtraction is applied.

Pointer writes cover every byte-enable pattern, plus an all-ones value. These tell the full-width rule and the hardwired upper bits apart from a plain register.

Random rounds mix pointer loads over all three regions with data reads and writes. The back-end acknowledges come after random delays. Each round checks the request that was seen, its address, byte enables and data, and the returned word. Separate cases cover a disabled window, the reserved offsets and the bus reset. Each is followed by a pointer read, so that state a faulty design might have changed is observed at the ports.

// File: rtl/iow_pkg.sv
package iow_pkg;
    typedef enum logic [1:0] {
        RGN_REG   = 2'd0,
        RGN_HOLE  = 2'd1,
        RGN_FLASH = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_REG   = 2'd1,
        ST_WAIT_FLASH = 2'd2
    } state_e;

    localparam logic [2:0] WOFF_PTR  = 3'd0;
    localparam logic [2:0] WOFF_DATA = 3'd1;
endpackage

// File: rtl/iow_ptr_reg.sv
module iow_ptr_reg #(
    parameter int unsigned PTR_W  = 20,
    parameter int unsigned BE_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             we,
    input  logic [BE_W-1:0]  be,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (bus_rst) begin
            ptr_d = '0;
        end else if (we && (&be)) begin
            ptr_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    AST_PARTIAL_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(&be) && !bus_rst) |=> $stable(ptr_q)); // R1

    AST_BUS_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (ptr_q == '0)); // R3
endmodule

// File: rtl/iow_region_dec.sv
module iow_region_dec
    import iow_pkg::*;
#(
    parameter int unsigned PTR_W  = 20,
    parameter int unsigned REG_AW = 17
) (
    input  logic [PTR_W-1:0]   ptr,
    output region_e            region,
    output logic [REG_AW-1:0]  reg_addr,
    output logic [PTR_W-2:0]   flash_addr
);
    localparam int unsigned     FLASH_AW   = PTR_W - 1;
    localparam logic [PTR_W-1:0] REG_LIMIT  = PTR_W'(1) << REG_AW;
    localparam logic [PTR_W-1:0] FLASH_BASE = PTR_W'(1) << FLASH_AW;

    always_comb begin
        if (ptr < REG_LIMIT)        region = RGN_REG;
        else if (ptr >= FLASH_BASE) region = RGN_FLASH;
        else                        region = RGN_HOLE;
    end

    assign reg_addr   = ptr[REG_AW-1:0];
    assign flash_addr = FLASH_AW'(ptr - FLASH_BASE);
endmodule

// File: rtl/iow_xfer_ctl.sv
module iow_xfer_ctl
    import iow_pkg::*;
#(
    parameter int unsigned PTR_W  = 20,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic              strobe,
    input  logic              wr,
    input  logic [2:0]        woff,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    input  region_e           region,
    input  logic [PTR_W-1:0]  ptr,
    output logic              ptr_we,
    output logic              hst_ack,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              be_wr,
    output logic [DATA_W/8-1:0] be_be,
    output logic [DATA_W-1:0] be_wdata,
    output logic              reg_req,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              flash_req,
    input  logic              flash_ack,
    input  logic [DATA_W-1:0] flash_rdata
);
    localparam int unsigned BE_W = DATA_W / 8;

    typedef struct packed {
        state_e            state;
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic              wr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
        logic              reg_req;
        logic              flash_req;
    } ctl_t;

    ctl_t q, d;
    logic accept;

    assign accept = (q.state == ST_IDLE) && strobe && enabled;
    assign ptr_we = accept && wr && (woff == WOFF_PTR);

    always_comb begin
        d = q;
        d.ack = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.wr    = wr;
                    d.be    = be;
                    d.wdata = wdata;
                    d.rdata = '0;
                    if (woff == WOFF_PTR) begin
                        d.ack = 1'b1;
                        if (!wr) d.rdata = DATA_W'(ptr);
                    end else if (woff == WOFF_DATA) begin
                        case (region)
                            RGN_REG: begin
                                d.reg_req = 1'b1;
                                d.state   = ST_WAIT_REG;
                            end
                            RGN_FLASH: begin
                                d.flash_req = 1'b1;
                                d.state     = ST_WAIT_FLASH;
                            end
                            default: d.ack = 1'b1;
                        endcase
                    end else begin
                        d.ack = 1'b1;
                    end
                end
            end
            ST_WAIT_REG: begin
                if (reg_ack) begin
                    d.reg_req = 1'b0;
                    d.ack     = 1'b1;
                    d.rdata   = q.wr ? '0 : reg_rdata;
                    d.state   = ST_IDLE;
                end
            end
            ST_WAIT_FLASH: begin
                if (flash_ack) begin
                    d.flash_req = 1'b0;
                    d.ack       = 1'b1;
                    d.rdata     = q.wr ? '0 : flash_rdata;
                    d.state     = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, ack: 1'b0, rdata: '0, wr: 1'b0,
                   be: '0, wdata: '0, reg_req: 1'b0, flash_req: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign hst_ack   = q.ack;
    assign hst_rdata = q.rdata;
    assign be_wr     = q.wr;
    assign be_be     = q.be;
    assign be_wdata  = q.wdata;
    assign reg_req   = q.reg_req;
    assign flash_req = q.flash_req;

    AST_DISABLED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_IDLE) && strobe && !enabled) |=> !hst_ack); // R8

    AST_PTR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr && (woff == WOFF_PTR)) |=> (hst_rdata[DATA_W-1:PTR_W] == '0)); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (woff > WOFF_DATA)) |=> (hst_ack && (hst_rdata == '0))); // R7

    AST_HOLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (woff == WOFF_DATA) && (region == RGN_HOLE))
        |=> (hst_ack && !reg_req && !flash_req)); // R6

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && flash_req)); // R9

    AST_ACK_FOLLOWS_BE: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_req && reg_ack) || (flash_req && flash_ack)) |=> (hst_ack && !reg_req && !flash_req)); // R9
endmodule

// File: rtl/iow_window.sv
module iow_window
    import iow_pkg::*;
#(
    parameter int unsigned PTR_W  = 20,
    parameter int unsigned REG_AW = 17,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W     = DATA_W / 8,
    localparam int unsigned FLASH_AW = PTR_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rst,
    input  logic                bar_valid,
    input  logic                io_dec_en,
    input  logic                hst_strobe,
    input  logic                hst_wr,
    input  logic [2:0]          hst_woff,
    input  logic [BE_W-1:0]     hst_be,
    input  logic [DATA_W-1:0]   hst_wdata,
    output logic                hst_ack,
    output logic [DATA_W-1:0]   hst_rdata,
    output logic                reg_req,
    output logic                reg_wr,
    output logic [REG_AW-1:0]   reg_addr,
    output logic [BE_W-1:0]     reg_be,
    output logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_ack,
    input  logic [DATA_W-1:0]   reg_rdata,
    output logic                flash_req,
    output logic                flash_wr,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic [BE_W-1:0]     flash_be,
    output logic [DATA_W-1:0]   flash_wdata,
    input  logic                flash_ack,
    input  logic [DATA_W-1:0]   flash_rdata
);
    logic              ptr_we;
    logic [PTR_W-1:0]  ptr;
    region_e           region;
    logic              be_wr;
    logic [BE_W-1:0]   be_be;
    logic [DATA_W-1:0] be_wdata;

    iow_ptr_reg #(.PTR_W(PTR_W), .BE_W(BE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .we(ptr_we), .be(hst_be), .wdata(hst_wdata[PTR_W-1:0]), .ptr(ptr)
    );

    iow_region_dec #(.PTR_W(PTR_W), .REG_AW(REG_AW)) u_dec (
        .ptr(ptr), .region(region), .reg_addr(reg_addr), .flash_addr(flash_addr)
    );

    iow_xfer_ctl #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .enabled(bar_valid && io_dec_en),
        .strobe(hst_strobe), .wr(hst_wr), .woff(hst_woff), .be(hst_be),
        .wdata(hst_wdata), .region(region), .ptr(ptr), .ptr_we(ptr_we),
        .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .be_wr(be_wr), .be_be(be_be), .be_wdata(be_wdata),
        .reg_req(reg_req), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .flash_req(flash_req), .flash_ack(flash_ack), .flash_rdata(flash_rdata)
    );

    assign reg_wr      = be_wr;
    assign reg_be      = be_be;
    assign reg_wdata   = be_wdata;
    assign flash_wr    = be_wr;
    assign flash_be    = be_be;
    assign flash_wdata = be_wdata;

    AST_REG_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr))); // R9

    AST_FLASH_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && !flash_ack) |=> (flash_req && $stable(flash_addr))); // R9
endmodule

// File: tb/iow_window_tb.sv
module iow_window_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0;
    logic bar_valid = 1'b1;
    logic io_dec_en = 1'b1;
    logic hst_strobe = 1'b0;
    logic hst_wr = 1'b0;
    logic [2:0] hst_woff = '0;
    logic [3:0] hst_be = '0;
    logic [31:0] hst_wdata = '0;
    logic hst_ack;
    logic [31:0] hst_rdata;
    logic reg_req, reg_wr, flash_req, flash_wr;
    logic [16:0] reg_addr;
    logic [18:0] flash_addr;
    logic [3:0] reg_be, flash_be;
    logic [31:0] reg_wdata, flash_wdata;
    logic reg_ack = 1'b0, flash_ack = 1'b0;
    logic [31:0] reg_rdata = '0, flash_rdata = '0;

    int checks = 0;
    int failures = 0;
    int reg_cnt = 0, flash_cnt = 0;
    logic [31:0] cap_addr, cap_wdata;
    logic [3:0] cap_be;
    logic cap_wr;
    logic [19:0] model_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iow_window u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bar_valid(bar_valid),
        .io_dec_en(io_dec_en), .hst_strobe(hst_strobe), .hst_wr(hst_wr),
        .hst_woff(hst_woff), .hst_be(hst_be), .hst_wdata(hst_wdata),
        .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .flash_req(flash_req), .flash_wr(flash_wr), .flash_addr(flash_addr),
        .flash_be(flash_be), .flash_wdata(flash_wdata), .flash_ack(flash_ack),
        .flash_rdata(flash_rdata)
    );

    function automatic logic [31:0] reg_word(input logic [31:0] a);
        return 32'hA500_0000 ^ a;
    endfunction
    function automatic logic [31:0] flash_word(input logic [31:0] a);
        return 32'h5A00_0000 ^ (a << 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // register-space responder
    initial begin
        forever begin
            @(negedge clk);
            if (reg_req) begin
                reg_cnt++;
                cap_addr = 32'(reg_addr); cap_wr = reg_wr; cap_be = reg_be; cap_wdata = reg_wdata;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                reg_rdata = reg_word(32'(reg_addr));
                reg_ack = 1'b1;
                @(negedge clk);
                reg_ack = 1'b0;
            end
        end
    end

    // flash responder
    initial begin
        forever begin
            @(negedge clk);
            if (flash_req) begin
                flash_cnt++;
                cap_addr = 32'(flash_addr); cap_wr = flash_wr; cap_be = flash_be; cap_wdata = flash_wdata;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                flash_rdata = flash_word(32'(flash_addr));
                flash_ack = 1'b1;
                @(negedge clk);
                flash_ack = 1'b0;
            end
        end
    end

    task automatic host_op(input logic wr, input logic [2:0] woff, input logic [3:0] be,
                           input logic [31:0] wd, output logic [31:0] rd, output logic acked);
        @(negedge clk);
        hst_strobe = 1'b1; hst_wr = wr; hst_woff = woff; hst_be = be; hst_wdata = wd;
        @(negedge clk);
        hst_strobe = 1'b0;
        acked = 1'b0;
        rd = '0;
        for (int i = 0; i < 20; i++) begin
            if (hst_ack) begin
                acked = 1'b1;
                rd = hst_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic read_ptr(input string req, input logic [31:0] exp);
        logic [31:0] rd; logic ak;
        host_op(1'b0, 3'd0, 4'hF, '0, rd, ak);
        chk({req, " ptr ack"}, 32'(ak), 32'd1);
        chk({req, " ptr value"}, rd, exp);
    endtask

    task automatic set_ptr(input logic [31:0] v);
        logic [31:0] rd; logic ak;
        host_op(1'b1, 3'd0, 4'hF, v, rd, ak);
        model_ptr = v[19:0];
    endtask

    // data access with expected outcome computed from the pointer model
    task automatic data_op(input logic wr, input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] rd; logic ak;
        int r0, f0;
        logic [31:0] p;
        r0 = reg_cnt; f0 = flash_cnt;
        p = 32'(model_ptr);
        host_op(wr, 3'd1, be, wd, rd, ak);
        chk("R9 data ack", 32'(ak), 32'd1);
        if (p < 32'h20000) begin
            chk("R4 reg req count", 32'(reg_cnt - r0), 32'd1);
            chk("R4 flash idle", 32'(flash_cnt - f0), 32'd0);
            chk("R4 reg addr", cap_addr, p);
            chk("R4 reg wr/be", {27'd0, cap_wr, cap_be}, {27'd0, wr, be});
            if (wr) chk("R4 reg wdata", cap_wdata, wd);
            else    chk("R4 reg rdata", rd, reg_word(p));
        end else if (p >= 32'h80000) begin
            chk("R5 flash req count", 32'(flash_cnt - f0), 32'd1);
            chk("R5 reg idle", 32'(reg_cnt - r0), 32'd0);
            chk("R5 flash addr", cap_addr, p - 32'h80000);
            chk("R5 flash wr/be", {27'd0, cap_wr, cap_be}, {27'd0, wr, be});
            if (wr) chk("R5 flash wdata", cap_wdata, wd);
            else    chk("R5 flash rdata", rd, flash_word(p - 32'h80000));
        end else begin
            chk("R6 hole no req", 32'((reg_cnt - r0) + (flash_cnt - f0)), 32'd0);
            chk("R6 hole read zero", rd, 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic ak;
        logic [31:0] edges [5];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state
        read_ptr("R3 reset", 32'd0);

        // R1 / R2: full write of all ones keeps only 20 bits
        set_ptr(32'hFFFF_FFFF);
        read_ptr("R2 upper zero", 32'h000F_FFFF);
        // R2: narrow pointer read returns full word
        host_op(1'b0, 3'd0, 4'h1, '0, rd, ak);
        chk("R2 narrow read", rd, 32'h000F_FFFF);

        // R1: every partial byte-enable pattern is ignored
        for (int b = 0; b < 15; b++) begin
            host_op(1'b1, 3'd0, 4'(b), 32'h0001_2345, rd, ak);
            read_ptr("R1 partial ignored", 32'h000F_FFFF);
        end
        set_ptr(32'h0001_2345);
        read_ptr("R1 full write", 32'h0001_2345);

        // R4 / R5 / R6 region edges
        edges[0] = 32'h1FFFF; edges[1] = 32'h20000; edges[2] = 32'h7FFFF;
        edges[3] = 32'h80000; edges[4] = 32'hFFFFF;
        for (int e = 0; e < 5; e++) begin
            set_ptr(edges[e]);
            data_op(1'b0, 4'hF, '0);
            data_op(1'b1, 4'h3, 32'hCAFE_0000 | edges[e]);
        end

        // R7: reserved offsets
        set_ptr(32'h0000_0ABC);
        for (int w = 2; w < 8; w++) begin
            host_op(1'b1, 3'(w), 4'hF, 32'h0000_0000, rd, ak);
            chk("R7 reserved write ack", 32'(ak), 32'd1);
            host_op(1'b0, 3'(w), 4'hF, '0, rd, ak);
            chk("R7 reserved read zero", rd, 32'd0);
            read_ptr("R7 ptr kept", 32'h0000_0ABC);
        end

        // R8: disabled window
        bar_valid = 1'b0;
        host_op(1'b1, 3'd0, 4'hF, 32'h0005_5555, rd, ak);
        chk("R8 no ack bar", 32'(ak), 32'd0);
        bar_valid = 1'b1; io_dec_en = 1'b0;
        host_op(1'b1, 3'd0, 4'hF, 32'h0005_5555, rd, ak);
        chk("R8 no ack decode", 32'(ak), 32'd0);
        io_dec_en = 1'b1;
        read_ptr("R8 ptr unchanged", 32'h0000_0ABC);

        // R3: bus reset clears pointer
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        read_ptr("R3 bus reset", 32'd0);

        // random mix across regions (R4 R5 R6 R9)
        for (int n = 0; n < 300; n++) begin
            logic [31:0] pv;
            case ($urandom_range(0, 2))
                0: pv = 32'($urandom_range(0, 32'h1FFFF));
                1: pv = 32'($urandom_range(32'h20000, 32'h7FFFF));
                default: pv = 32'($urandom_range(32'h80000, 32'hFFFFF));
            endcase
            if ($urandom_range(0, 3) == 0) pv = pv | 32'hFFF0_0000;
            set_ptr(pv);
            data_op(1'($urandom_range(0, 1)), 4'($urandom_range(1, 15)), $urandom());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule